// File: doc/BRIEF.md
# Extended Palette RGB Access Sequencer

This block holds a small extended colour palette of four entries, used by the display pipeline for overscan and cursor colours. A host reaches it through one byte-wide port. The host first loads a write index or a read index. It then moves colour data through a single data strobe, one component per access, always in red, green, blue order. A shared byte-position counter tracks which component comes next.

A write is held back until the whole triplet has arrived. Red and green wait in staging registers, and all three components land in the entry together when blue is written. Only the low two bits of each index pick the entry, so the index counters wrap over the four entries.

Every entry is always visible to the pixel path as 24-bit colour. When the host selects the narrow 6-bit DAC mode, each component is widened to 8 bits for display. Entry 0 can also be steered out as the border colour.

Top module: `xpal_seq`

## Requirements
- R1: After reset all four entries are black (zero), both index counters are zero and the byte position is red. The first data read returns 0 and the first triplet written lands in entry 0.
- R2: Data writes are taken in the order red, green, blue. No entry changes on a red or green write. On the blue write, the entry takes {staged red, staged green, blue}, visible on the outputs one clock later.
- R3: After a blue write is committed, the write index increments and the byte position returns to red. The entry written is the write index modulo 4, so index 4 addresses entry 0 and index 6 addresses entry 2.
- R4: Data reads return red, then green, then blue of the entry at the read index modulo 4. After the blue read, the read index increments and the byte position returns to red.
- R5: When `dac8_mode` is 0 (6-bit mode), each byte read back is the stored component with its top two bits cleared. When it is 1, the full stored byte is returned.
- R6: `pal_rgb` carries entry e in bits [24e+23:24e], red in the top byte and blue in the low byte. In 8-bit mode each component is shown as stored. In 6-bit mode the component c is shown as {c[5:0], c[5:4]}.
- R7: With `ovs_en` at 1, `border_rgb` equals entry 0 as shown on `pal_rgb`. With `ovs_en` at 0 it is zero. It follows a rewrite of entry 0 one clock after the blue write.
- R8: Loading either the write index or the read index returns the byte position to red, discarding a partly transferred triplet.
- R9: In a cycle with an index load, any data strobe is ignored. In a cycle with both data strobes, the write is taken and the read is ignored (its index and position do not move).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_din | input | 8 | Host byte: index value on index loads, component on data writes |
| widx_ld | input | 1 | Load write index from `host_din` |
| ridx_ld | input | 1 | Load read index from `host_din` |
| data_wr | input | 1 | Data write strobe, one component per cycle |
| data_rd | input | 1 | Data read strobe, advances position on the clock edge |
| host_dout | output | 8 | Component at the read index and current position (combinational) |
| dac8_mode | input | 1 | 1 = 8-bit components, 0 = 6-bit components |
| ovs_en | input | 1 | Route entry 0 to the border colour |
| pal_rgb | output | 96 | All four entries as displayed, entry 0 in the low 24 bits |
| border_rgb | output | 24 | Border colour |

## Verification
On every cycle the assertions check the following. The position never takes its unused code. Index loads force the position back to red. A committed blue write or a blue read advances the matching index by one. Stored entries stay still on all cycles that are not a commit. In 8-bit mode the displayed colour equals the stored colour, and the border tracks entry 0 or black. The bench scenarios are needed to show the data values themselves: a staged triplet committing intact, index wrap over four entries, masking of readback and widening for display in 6-bit mode, the discarding of a partial triplet after an index load, and the arbitration between simultaneous strobes.

// File: rtl/xpal_pkg.sv
package xpal_pkg;
  typedef enum logic [1:0] {
    POS_R = 2'd0,
    POS_G = 2'd1,
    POS_B = 2'd2
  } pos_e;
endpackage

// File: rtl/xpal_ctrl.sv
module xpal_ctrl
  import xpal_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             widx_ld,
  input  logic             ridx_ld,
  input  logic [DW-1:0]    idx_val,
  input  logic             data_wr,
  input  logic             data_rd,
  output pos_e             pos,
  output logic [DW-1:0]    wr_idx,
  output logic [DW-1:0]    rd_idx,
  output logic             stage_r_en,
  output logic             stage_g_en,
  output logic             commit
);
  logic    any_ld, wr_ok, rd_ok, at_blue;
  pos_e    pos_n;
  logic [DW-1:0] wr_idx_n, rd_idx_n;

  assign any_ld  = widx_ld | ridx_ld;
  assign wr_ok   = data_wr & ~any_ld;
  assign rd_ok   = data_rd & ~data_wr & ~any_ld;
  assign at_blue = (pos == POS_B);

  assign stage_r_en = wr_ok & (pos == POS_R);
  assign stage_g_en = wr_ok & (pos == POS_G);
  assign commit     = wr_ok & at_blue;

  always_comb begin
    pos_n = pos;
    if (any_ld)
      pos_n = POS_R;
    else if (wr_ok | rd_ok)
      pos_n = at_blue ? POS_R : pos_e'(pos + 2'd1);
  end

  always_comb begin
    wr_idx_n = wr_idx;
    if (widx_ld)
      wr_idx_n = idx_val;
    else if (commit)
      wr_idx_n = wr_idx + 1'b1;
  end

  always_comb begin
    rd_idx_n = rd_idx;
    if (ridx_ld)
      rd_idx_n = idx_val;
    else if (rd_ok & at_blue)
      rd_idx_n = rd_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= POS_R;
      wr_idx <= '0;
      rd_idx <= '0;
    end else begin
      pos    <= pos_n;
      wr_idx <= wr_idx_n;
      rd_idx <= rd_idx_n;
    end
  end
endmodule

// File: rtl/xpal_store.sv
module xpal_store #(
  parameter int DW      = 8,
  parameter int ENTRIES = 4,
  parameter int SEL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stage_r_en,
  input  logic                      stage_g_en,
  input  logic                      commit,
  input  logic [SEL_W-1:0]          wsel,
  input  logic [DW-1:0]             din,
  output logic [ENTRIES*3*DW-1:0]   ent_flat
);
  logic [DW-1:0] stage_r, stage_g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_r <= '0;
      stage_g <= '0;
    end else begin
      if (stage_r_en) stage_r <= din;
      if (stage_g_en) stage_g <= din;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic            en;
    logic [3*DW-1:0] ent_q;
    assign en = commit & (wsel == SEL_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q <= '0;
      else if (en)
        ent_q <= {stage_r, stage_g, din};
    end
    assign ent_flat[e*3*DW +: 3*DW] = ent_q;
  end
endmodule

// File: rtl/xpal_widen.sv
module xpal_widen #(
  parameter int DW = 8
) (
  input  logic            dac8_mode,
  input  logic [3*DW-1:0] rgb_in,
  output logic [3*DW-1:0] rgb_out
);
  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [DW-1:0] v;
    assign v = rgb_in[c*DW +: DW];
    assign rgb_out[c*DW +: DW] = dac8_mode ? v : {v[DW-3:0], v[DW-3:DW-4]};
  end
endmodule

// File: rtl/xpal_seq.sv
module xpal_seq
  import xpal_pkg::*;
#(
  parameter int DW      = 8,
  parameter int ENTRIES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DW-1:0]           host_din,
  input  logic                    widx_ld,
  input  logic                    ridx_ld,
  input  logic                    data_wr,
  input  logic                    data_rd,
  output logic [DW-1:0]           host_dout,
  input  logic                    dac8_mode,
  input  logic                    ovs_en,
  output logic [ENTRIES*3*DW-1:0] pal_rgb,
  output logic [3*DW-1:0]         border_rgb
);
  localparam int SEL_W = $clog2(ENTRIES);
  localparam int EW    = 3 * DW;

  logic [1:0] rst_sync;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  pos_e                  pos;
  logic [DW-1:0]         wr_idx, rd_idx;
  logic                  stage_r_en, stage_g_en, commit;
  logic [ENTRIES*EW-1:0] ent_flat;

  xpal_ctrl #(.DW(DW), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_ns),
    .widx_ld(widx_ld), .ridx_ld(ridx_ld), .idx_val(host_din),
    .data_wr(data_wr), .data_rd(data_rd),
    .pos(pos), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .stage_r_en(stage_r_en), .stage_g_en(stage_g_en), .commit(commit)
  );

  xpal_store #(.DW(DW), .ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_ns),
    .stage_r_en(stage_r_en), .stage_g_en(stage_g_en), .commit(commit),
    .wsel(wr_idx[SEL_W-1:0]), .din(host_din),
    .ent_flat(ent_flat)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_disp
    xpal_widen #(.DW(DW)) u_widen (
      .dac8_mode(dac8_mode),
      .rgb_in(ent_flat[e*EW +: EW]),
      .rgb_out(pal_rgb[e*EW +: EW])
    );
  end

  logic [EW-1:0] rd_ent;
  logic [DW-1:0] rd_comp;

  assign rd_ent = ent_flat[int'(rd_idx[SEL_W-1:0])*EW +: EW];

  always_comb begin
    case (pos)
      POS_R:   rd_comp = rd_ent[2*DW +: DW];
      POS_G:   rd_comp = rd_ent[DW +: DW];
      default: rd_comp = rd_ent[0 +: DW];
    endcase
  end

  assign host_dout  = dac8_mode ? rd_comp : (rd_comp & {2'b00, {(DW-2){1'b1}}});
  assign border_rgb = ovs_en ? pal_rgb[0 +: EW] : '0;
endmodule

// File: rtl/xpal_seq_chk.sv
module xpal_seq_chk #(
  parameter int DW      = 8,
  parameter int ENTRIES = 4
) (
  input logic                    clk,
  input logic                    rst_ns,
  input logic [DW-1:0]           host_din,
  input logic                    widx_ld,
  input logic                    ridx_ld,
  input logic                    data_wr,
  input logic                    data_rd,
  input logic                    dac8_mode,
  input logic                    ovs_en,
  input logic [1:0]              pos,
  input logic [DW-1:0]           wr_idx,
  input logic [DW-1:0]           rd_idx,
  input logic [ENTRIES*3*DW-1:0] ent_flat,
  input logic [ENTRIES*3*DW-1:0] pal_rgb,
  input logic [3*DW-1:0]         border_rgb
);
  logic no_ld;
  assign no_ld = ~widx_ld & ~ridx_ld;

  p_pos_legal_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    pos != 2'd3);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    !(data_wr && no_ld && pos == 2'd2) |=> $stable(ent_flat));

  p_wr_adv_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (data_wr && no_ld && pos == 2'd2) |=> (wr_idx == $past(wr_idx) + 1'b1) && pos == 2'd0);

  p_rd_adv_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (data_rd && !data_wr && no_ld && pos == 2'd2) |=> (rd_idx == $past(rd_idx) + 1'b1) && pos == 2'd0);

  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    dac8_mode |-> pal_rgb == ent_flat);

  p_border_on_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    ovs_en |-> border_rgb == pal_rgb[3*DW-1:0]);

  p_border_off_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    !ovs_en |-> border_rgb == '0);

  p_ld_pos_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (widx_ld || ridx_ld) |=> pos == 2'd0);

  p_ld_wins_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    widx_ld |=> wr_idx == $past(host_din));

  p_rd_drop_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (data_wr && data_rd && no_ld) |=> $stable(rd_idx));
endmodule

bind xpal_seq xpal_seq_chk #(.DW(DW), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .host_din(host_din),
  .widx_ld(widx_ld), .ridx_ld(ridx_ld), .data_wr(data_wr), .data_rd(data_rd),
  .dac8_mode(dac8_mode), .ovs_en(ovs_en),
  .pos(pos), .wr_idx(wr_idx), .rd_idx(rd_idx), .ent_flat(ent_flat),
  .pal_rgb(pal_rgb), .border_rgb(border_rgb)
);

// File: tb/tb_xpal_seq.sv
`timescale 1ns/1ps
module tb_xpal_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  host_din;
  logic        widx_ld, ridx_ld, data_wr, data_rd;
  logic [7:0]  host_dout;
  logic        dac8_mode, ovs_en;
  logic [95:0] pal_rgb;
  logic [23:0] border_rgb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  xpal_seq dut (
    .clk(clk), .rst_n(rst_n), .host_din(host_din),
    .widx_ld(widx_ld), .ridx_ld(ridx_ld), .data_wr(data_wr), .data_rd(data_rd),
    .host_dout(host_dout), .dac8_mode(dac8_mode), .ovs_en(ovs_en),
    .pal_rgb(pal_rgb), .border_rgb(border_rgb)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] ent(input int e);
    return pal_rgb[e*24 +: 24];
  endfunction

  function automatic logic [23:0] widen6(input logic [23:0] v);
    logic [23:0] r;
    for (int c = 0; c < 3; c++) begin
      logic [7:0] x;
      x = v[c*8 +: 8];
      r[c*8 +: 8] = {x[5:0], x[5:4]};
    end
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
    widx_ld = 0; ridx_ld = 0; data_wr = 0; data_rd = 0;
  endtask

  task automatic set_widx(input logic [7:0] v);
    host_din = v; widx_ld = 1; step();
  endtask

  task automatic set_ridx(input logic [7:0] v);
    host_din = v; ridx_ld = 1; step();
  endtask

  task automatic wr_byte(input logic [7:0] v);
    host_din = v; data_wr = 1; step();
  endtask

  task automatic rd_byte(output logic [7:0] v);
    data_rd = 1; #1; v = host_dout; step();
  endtask

  task automatic wr_rgb(input logic [23:0] v);
    wr_byte(v[23:16]); wr_byte(v[15:8]); wr_byte(v[7:0]);
  endtask

  task automatic rd_expect(input string tag, input logic [23:0] v);
    logic [7:0] b;
    rd_byte(b); check(tag, {24'h0, b}, {24'h0, v[23:16]});
    rd_byte(b); check(tag, {24'h0, b}, {24'h0, v[15:8]});
    rd_byte(b); check(tag, {24'h0, b}, {24'h0, v[7:0]});
  endtask

  task automatic t_reset();
    rst_n = 0; host_din = 0; widx_ld = 0; ridx_ld = 0; data_wr = 0; data_rd = 0;
    dac8_mode = 1; ovs_en = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    for (int e = 0; e < 4; e++) check("R1 entry black", {8'h0, ent(e)}, 32'h0);
    check("R1 border black", {8'h0, border_rgb}, 32'h0);
    check("R1 read returns 0", {24'h0, host_dout}, 32'h0);
  endtask

  task automatic t_write_order();
    wr_byte(8'h12); check("R2 no change after red", {8'h0, ent(0)}, 32'h0);
    wr_byte(8'h34); check("R2 no change after green", {8'h0, ent(0)}, 32'h0);
    wr_byte(8'h56); check("R2 commit on blue", {8'h0, ent(0)}, 32'h123456);
    check("R1 first triplet to entry 0", {8'h0, ent(1)}, 32'h0);
  endtask

  task automatic t_index_wrap();
    wr_rgb(24'hA1B2C3); wr_rgb(24'h112233); wr_rgb(24'h445566);
    check("R3 entry1", {8'h0, ent(1)}, 32'hA1B2C3);
    check("R3 entry2", {8'h0, ent(2)}, 32'h112233);
    check("R3 entry3", {8'h0, ent(3)}, 32'h445566);
    wr_rgb(24'h778899);
    check("R3 index 4 wraps to entry0", {8'h0, ent(0)}, 32'h778899);
    set_widx(8'h06); wr_rgb(24'hDEAD01);
    check("R3 index 6 selects entry2", {8'h0, ent(2)}, 32'hDEAD01);
  endtask

  task automatic t_read();
    set_ridx(8'h05);
    rd_expect("R4 read entry1", 24'hA1B2C3);
    rd_expect("R4 read index advanced", 24'hDEAD01);
    set_ridx(8'h03);
    rd_expect("R4 read entry3", 24'h445566);
    begin
      logic [7:0] b;
      rd_byte(b); check("R4 read index wraps to entry0", {24'h0, b}, 32'h77);
    end
  endtask

  task automatic t_six_bit();
    dac8_mode = 0;
    set_ridx(8'h01);
    rd_expect("R5 masked readback", 24'h213203);
    check("R6 widened entry1", {8'h0, ent(1)}, {8'h0, widen6(24'hA1B2C3)});
    check("R6 widened entry3", {8'h0, ent(3)}, {8'h0, widen6(24'h445566)});
    check("R7 border widened", {8'h0, border_rgb}, {8'h0, widen6(24'h778899)});
    dac8_mode = 1; #1;
    check("R6 8-bit passthrough", {8'h0, ent(1)}, 32'hA1B2C3);
  endtask

  task automatic t_border();
    ovs_en = 0; #1;
    check("R7 border off", {8'h0, border_rgb}, 32'h0);
    ovs_en = 1; #1;
    check("R7 border on", {8'h0, border_rgb}, 32'h778899);
    set_widx(8'h00);
    wr_byte(8'h5A); wr_byte(8'h6B);
    check("R7 border held before blue", {8'h0, border_rgb}, 32'h778899);
    wr_byte(8'h7C);
    check("R7 border follows entry0", {8'h0, border_rgb}, 32'h5A6B7C);
  endtask

  task automatic t_pos_reset();
    logic [7:0] b;
    set_widx(8'h01);
    wr_byte(8'hFF); wr_byte(8'hEE);
    set_widx(8'h01);
    wr_rgb(24'h102030);
    check("R8 partial triplet discarded", {8'h0, ent(1)}, 32'h102030);
    set_ridx(8'h01);
    rd_byte(b); check("R8 read red", {24'h0, b}, 32'h10);
    set_ridx(8'h01);
    rd_byte(b); check("R8 read restarts at red", {24'h0, b}, 32'h10);
  endtask

  task automatic t_priority();
    logic [7:0] b;
    host_din = 8'h03; widx_ld = 1; data_wr = 1; step();
    wr_rgb(24'h0A0B0C);
    check("R9 data dropped on index load", {8'h0, ent(3)}, 32'h0A0B0C);
    set_widx(8'h02); set_ridx(8'h00);
    wr_byte(8'h01); wr_byte(8'h02);
    host_din = 8'h03; data_wr = 1; data_rd = 1; step();
    check("R9 write wins", {8'h0, ent(2)}, 32'h010203);
    rd_byte(b); check("R9 read ignored", {24'h0, b}, 32'h5A);
  endtask

  initial begin
    t_reset();
    t_write_order();
    t_index_wrap();
    t_read();
    t_six_bit();
    t_border();
    t_pos_reset();
    t_priority();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule